// File: doc/BRIEF.md
# Shared Last-Level Cache Slice Request Router

The router sits between the cores of a multi-core chip and the sixteen slices of a shared last-level cache that is spread across the die as tiles. Each core offers a 40-bit physical address on its own valid/ready port. The router decodes the line address into a tag, a slice number and a set index local to that slice, then writes the request into a small queue in front of the chosen slice. The slice drains its queue with its own valid/ready pair. The core number is the index of the requesting port, and it travels with the request so that a reply can find its way back.

The slice number comes from four set-index bits that also belong to the page number of an 8 KB page. The operating system's choice of physical page therefore sets which slice caches a line. The cache is 32 MB, 8-way, with 64-byte lines, which gives 64K sets overall. Each slice keeps 4K of them, addressed by the remaining twelve index bits.

The router accepts at most one request per clock. A round-robin pointer chooses among the cores whose target queue has room. A core whose slice queue is full sees ready held low, and it keeps its request on the port until space frees up.

Top module: `slice_router`

## Requirements
- R1: For an accepted address A, the slice entry carries tag = A[39:22] on `sliceTag` and local set index = A[17:6] on `sliceIndex`.
- R2: The destination slice is A[21:18]. A request with A[21:18] = 0 goes to slice 0. The block offset A[5:0] has no effect on routing or on the fields.
- R3: The slice entry carries, on `sliceCore`, the number of the core port that issued the request.
- R4: `reqReady` has at most one bit set, and only for a core whose `reqValid` is high. A request is accepted in a cycle where both are high.
- R5: Round-robin grant. After reset the search starts at core 0. After an acceptance from core g it starts at core g+1, wrapping to 0. Cycles with no acceptance leave the start point unchanged.
- R6: Each slice has a 4-entry queue that delivers entries in the order they were accepted.
- R7: While the target slice queue holds 4 entries, `reqReady` stays low for that core. The core's request is accepted in the first cycle after a pop leaves space.
- R8: After reset every slice queue is empty, so `sliceValid` = 0, and no `reqReady` bit is set while no core is valid.
- R9: An accepted request shows on its slice's `sliceValid` and fields in the clock cycle after the acceptance edge. A slice entry is removed at an edge where `sliceValid` and `sliceReady` are both high.
- R10: A full slice queue does not block a core whose request targets a slice with room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 4 | Request valid, one bit per core |
| reqAddr | input | 160 | Physical address per core, core c in bits [40c+39:40c] |
| reqReady | output | 4 | Request accepted this cycle, one bit per core |
| sliceReady | input | 16 | Slice takes its head entry, one bit per slice |
| sliceValid | output | 16 | Slice queue not empty, one bit per slice |
| sliceTag | output | 288 | Head tag per slice, slice s in bits [18s+17:18s] |
| sliceIndex | output | 192 | Head local set index per slice, slice s in bits [12s+11:12s] |
| sliceCore | output | 32 | Head requesting core per slice, slice s in bits [2s+1:2s] |

## Verification
The ready decision is combinational in the current valid and address inputs and in the queue fill. The bench therefore reads `reqReady` one time unit after it drives a request at the falling edge, before the rising edge that accepts it. A queue entry is due one rising edge after acceptance, and a pop one rising edge after `sliceReady` is raised, so the bench checks slice outputs at the next falling edge. Round-robin order is checked cycle by cycle with several cores valid at once. Idle cycles are inserted to show that the start point holds. The full-queue case is checked with the blocked core and an unblocked core competing in the same cycle.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int ADDR_W     = 40;
  localparam int OFFSET_W   = 6;
  localparam int INDEX_W    = 16;
  localparam int SLICE_W    = 4;
  localparam int NUM_SLICES = 1 << SLICE_W;
  localparam int TAG_W      = ADDR_W - OFFSET_W - INDEX_W;
  localparam int LOCAL_W    = INDEX_W - SLICE_W;
  localparam int SLICE_LSB  = OFFSET_W + LOCAL_W;
  localparam int TAG_LSB    = OFFSET_W + INDEX_W;
  localparam int NUM_CORES  = 4;
  localparam int CORE_W     = $clog2(NUM_CORES);

  typedef struct packed {
    logic                wrEn;
    logic [CORE_W-1:0]   wrCore;
    logic [SLICE_W-1:0]  wrSlice;
  } strobe_t;

  typedef struct packed {
    logic [TAG_W-1:0]    tag;
    logic [LOCAL_W-1:0]  loc;
    logic [CORE_W-1:0]   core;
  } entry_t;
endpackage

// File: rtl/slice_fifo.sv
module slice_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         notEmpty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;
  assign head     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import router_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES-1:0]          reqValid,
  input  logic [NUM_CORES*SLICE_W-1:0]  coreSlice,
  input  logic [NUM_SLICES-1:0]         sliceFull,
  output logic [NUM_CORES-1:0]          reqReady,
  output strobe_t                       strobe
);
  logic [CORE_W-1:0]    rrPtr;
  logic [NUM_CORES-1:0] eligible;
  logic [CORE_W-1:0]    gIdx;
  logic                 found;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      eligible[c] = reqValid[c] && !sliceFull[coreSlice[c*SLICE_W +: SLICE_W]];
    end
  end

  always_comb begin
    int i;
    found = 1'b0;
    gIdx  = '0;
    for (int off = 0; off < NUM_CORES; off++) begin
      i = (int'(rrPtr) + off) % NUM_CORES;
      if (!found && eligible[i]) begin
        found = 1'b1;
        gIdx  = CORE_W'(i);
      end
    end
  end

  always_comb begin
    reqReady       = found ? (NUM_CORES'(1) << gIdx) : '0;
    strobe.wrEn    = found;
    strobe.wrCore  = gIdx;
    strobe.wrSlice = coreSlice[gIdx*SLICE_W +: SLICE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.wrEn) begin
      rrPtr <= (gIdx == CORE_W'(NUM_CORES - 1)) ? '0 : gIdx + 1'b1;
    end
  end
endmodule

// File: rtl/router_dpath.sv
module router_dpath
  import router_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CORES*ADDR_W-1:0]    reqAddr,
  input  strobe_t                        strobe,
  input  logic [NUM_SLICES-1:0]          sliceReady,
  output logic [NUM_CORES*SLICE_W-1:0]   coreSlice,
  output logic [NUM_SLICES-1:0]          sliceFull,
  output logic [NUM_SLICES-1:0]          sliceValid,
  output logic [NUM_SLICES*TAG_W-1:0]    sliceTag,
  output logic [NUM_SLICES*LOCAL_W-1:0]  sliceIndex,
  output logic [NUM_SLICES*CORE_W-1:0]   sliceCore
);
  localparam int ENTRY_W = $bits(entry_t);

  entry_t wrEntry;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      coreSlice[c*SLICE_W +: SLICE_W] = reqAddr[c*ADDR_W + SLICE_LSB +: SLICE_W];
    end
  end

  always_comb begin
    wrEntry.tag  = reqAddr[strobe.wrCore*ADDR_W + TAG_LSB +: TAG_W];
    wrEntry.loc  = reqAddr[strobe.wrCore*ADDR_W + OFFSET_W +: LOCAL_W];
    wrEntry.core = strobe.wrCore;
  end

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    entry_t headEntry;
    logic   pushHere;

    assign pushHere = strobe.wrEn && (strobe.wrSlice == SLICE_W'(s));

    slice_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushHere),
      .pushData (wrEntry),
      .pop      (sliceReady[s]),
      .notEmpty (sliceValid[s]),
      .full     (sliceFull[s]),
      .head     (headEntry)
    );

    assign sliceTag[s*TAG_W +: TAG_W]       = headEntry.tag;
    assign sliceIndex[s*LOCAL_W +: LOCAL_W] = headEntry.loc;
    assign sliceCore[s*CORE_W +: CORE_W]    = headEntry.core;
  end
endmodule

// File: rtl/slice_router.sv
module slice_router
  import router_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CORES-1:0]           reqValid,
  input  logic [NUM_CORES*ADDR_W-1:0]    reqAddr,
  output logic [NUM_CORES-1:0]           reqReady,
  input  logic [NUM_SLICES-1:0]          sliceReady,
  output logic [NUM_SLICES-1:0]          sliceValid,
  output logic [NUM_SLICES*TAG_W-1:0]    sliceTag,
  output logic [NUM_SLICES*LOCAL_W-1:0]  sliceIndex,
  output logic [NUM_SLICES*CORE_W-1:0]   sliceCore
);
  strobe_t                       strobe;
  logic [NUM_CORES*SLICE_W-1:0]  coreSlice;
  logic [NUM_SLICES-1:0]         sliceFull;

  router_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .coreSlice (coreSlice),
    .sliceFull (sliceFull),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  router_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .strobe     (strobe),
    .sliceReady (sliceReady),
    .coreSlice  (coreSlice),
    .sliceFull  (sliceFull),
    .sliceValid (sliceValid),
    .sliceTag   (sliceTag),
    .sliceIndex (sliceIndex),
    .sliceCore  (sliceCore)
  );
endmodule

// File: rtl/slice_router_chk.sv
module slice_router_chk
  import router_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CORES-1:0]         reqValid,
  input logic [NUM_CORES*ADDR_W-1:0]  reqAddr,
  input logic [NUM_CORES-1:0]         reqReady,
  input logic [NUM_SLICES-1:0]        sliceReady,
  input logic [NUM_SLICES-1:0]        sliceValid
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [SLICE_W-1:0]   target [NUM_CORES];
  logic [NUM_SLICES-1:0] pushS;

  always_comb begin
    pushS = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      target[c] = reqAddr[c*ADDR_W + SLICE_LSB +: SLICE_W];
      if (reqValid[c] && reqReady[c]) pushS[target[c]] = 1'b1;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady)); // R4
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady & ~reqValid) == '0); // R4

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_occ
    logic [CNT_W-1:0] occ;
    logic             popS;
    assign popS = sliceValid[s] && sliceReady[s];

    always_ff @(posedge clk) begin
      if (!rstN) occ <= '0;
      else occ <= occ + CNT_W'(pushS[s]) - CNT_W'(popS);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      occ <= CNT_W'(FIFO_DEPTH)); // R6
    AST_VALID_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rstN)
      sliceValid[s] == (occ != '0)); // R9
    AST_PUSH_SHOWS_NEXT: assert property (@(posedge clk) disable iff (!rstN)
      pushS[s] |=> sliceValid[s]); // R9

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
        (occ == CNT_W'(FIFO_DEPTH) && target[c] == SLICE_W'(s)) |-> !reqReady[c]); // R7
    end
  end
endmodule

bind slice_router slice_router_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqReady   (reqReady),
  .sliceReady (sliceReady),
  .sliceValid (sliceValid)
);

// File: tb/slice_router_bench.sv
module slice_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NC-1:0] reqValid;
  logic [NC*40-1:0] reqAddr;
  logic [NC-1:0] reqReady;
  logic [NS-1:0] sliceReady;
  logic [NS-1:0] sliceValid;
  logic [NS*18-1:0] sliceTag;
  logic [NS*12-1:0] sliceIndex;
  logic [NS*2-1:0]  sliceCore;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_router u_slice_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .sliceReady(sliceReady), .sliceValid(sliceValid),
    .sliceTag(sliceTag), .sliceIndex(sliceIndex), .sliceCore(sliceCore)
  );

  typedef struct packed {
    logic [1:0]  core;
    logic [17:0] tag;
    logic [3:0]  slice;
    logic [11:0] loc;
    logic [5:0]  off;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{core: 2'd0, tag: 18'h00000, slice: 4'h0, loc: 12'h000, off: 6'h3F},
    '{core: 2'd1, tag: 18'h3FFFF, slice: 4'hF, loc: 12'hFFF, off: 6'h00},
    '{core: 2'd2, tag: 18'h12345, slice: 4'h5, loc: 12'hA5A, off: 6'h15},
    '{core: 2'd0, tag: 18'h2AAAA, slice: 4'h8, loc: 12'h001, off: 6'h2A},
    '{core: 2'd1, tag: 18'h00001, slice: 4'h0, loc: 12'h800, off: 6'h01},
    '{core: 2'd3, tag: 18'h15555, slice: 4'hA, loc: 12'h3C3, off: 6'h20}
  };

  function automatic logic [39:0] mkAddr(input logic [17:0] t, input logic [3:0] s,
                                         input logic [11:0] l, input logic [5:0] o);
    return {t, s, l, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic setReq(input int c, input logic [39:0] a);
    reqAddr[c*40 +: 40] = a;
    reqValid[c] = 1'b1;
  endtask

  task automatic popSlice(input int s);
    sliceReady[s] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sliceReady[s] = 1'b0;
  endtask

  task automatic checkHead(input int s, input logic [17:0] t, input logic [11:0] l,
                           input logic [1:0] c, input string req);
    chk(sliceValid[s] === 1'b1, {req, " valid"}, 64'(sliceValid[s]), 64'd1);
    chk(sliceTag[s*18 +: 18] === t, {req, " tag (R1)"}, 64'(sliceTag[s*18 +: 18]), 64'(t));
    chk(sliceIndex[s*12 +: 12] === l, {req, " index (R1)"}, 64'(sliceIndex[s*12 +: 12]), 64'(l));
    chk(sliceCore[s*2 +: 2] === c, {req, " core (R3)"}, 64'(sliceCore[s*2 +: 2]), 64'(c));
  endtask

  task automatic expectGrant(input logic [NC-1:0] exp, input string req);
    #1;
    chk(reqReady === exp, req, 64'(reqReady), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    reqValid = '0;
    reqAddr = '0;
    sliceReady = '0;
    repeat (3) @(negedge clk);
    chk(sliceValid === '0, "R8 slices empty in reset", 64'(sliceValid), 0);
    chk(reqReady === '0, "R8 no ready in reset", 64'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sliceValid === '0, "R8 slices empty after reset", 64'(sliceValid), 0);

    // Table walk: R1 R2 R3 R9
    for (int v = 0; v < 6; v++) begin
      setReq(VECS[v].core, mkAddr(VECS[v].tag, VECS[v].slice, VECS[v].loc, VECS[v].off));
      expectGrant(NC'(1) << VECS[v].core, "R4 single requester granted");
      @(posedge clk);
      @(negedge clk);
      reqValid = '0;
      chk(sliceValid === (NS'(1) << VECS[v].slice), "R2 R9 only target slice valid",
          64'(sliceValid), 64'(NS'(1) << VECS[v].slice));
      checkHead(int'(VECS[v].slice), VECS[v].tag, VECS[v].loc, VECS[v].core, "R1 R3 vector");
      popSlice(int'(VECS[v].slice));
      chk(sliceValid === '0, "R9 pop empties slice", 64'(sliceValid), 0);
    end

    // R5: round robin, pointer back at core 0 after last vector from core 3
    for (int c = 0; c < NC; c++) setReq(c, mkAddr(18'h100 + 18'(c), 4'(c + 1), 12'(c), 6'h0));
    for (int c = 0; c < NC; c++) begin
      expectGrant(NC'(1) << c, "R5 round robin order");
      @(posedge clk);
      @(negedge clk);
      reqValid[c] = 1'b0;
    end
    sliceReady = '1;
    @(posedge clk);
    @(negedge clk);
    sliceReady = '0;
    chk(sliceValid === '0, "R9 all drained", 64'(sliceValid), 0);

    setReq(2, mkAddr(18'h7, 4'h3, 12'h7, 6'h0));
    expectGrant(4'b0100, "R5 lone core 2");
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
    repeat (3) @(negedge clk);
    setReq(0, mkAddr(18'h8, 4'h4, 12'h8, 6'h0));
    setReq(1, mkAddr(18'h9, 4'h5, 12'h9, 6'h0));
    setReq(3, mkAddr(18'hA, 4'h6, 12'hA, 6'h0));
    expectGrant(4'b1000, "R5 pointer held over idle cycles");
    @(posedge clk);
    @(negedge clk);
    reqValid[3] = 1'b0;
    expectGrant(4'b0001, "R5 wrap to core 0");
    @(posedge clk);
    @(negedge clk);
    reqValid[0] = 1'b0;
    expectGrant(4'b0010, "R5 then core 1");
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
    sliceReady = '1;
    @(posedge clk);
    @(negedge clk);
    sliceReady = '0;

    // R6 R7 R10: fill slice 5 from core 0
    for (int k = 0; k < 4; k++) begin
      setReq(0, mkAddr(18'h55, 4'h5, 12'(k), 6'h0));
      @(posedge clk);
      @(negedge clk);
      reqValid = '0;
    end
    setReq(0, mkAddr(18'h55, 4'h5, 12'd4, 6'h0));
    setReq(1, mkAddr(18'h66, 4'h6, 12'h66, 6'h0));
    expectGrant(4'b0010, "R7 R10 full slice skipped, other core served");
    @(posedge clk);
    @(negedge clk);
    reqValid[1] = 1'b0;
    expectGrant(4'b0000, "R7 ready low while full");
    checkHead(6, 18'h66, 12'h66, 2'd1, "R10 other slice");
    checkHead(5, 18'h55, 12'd0, 2'd0, "R6 oldest first");
    popSlice(5);
    expectGrant(4'b0001, "R7 accepted after space frees");
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
    for (int k = 1; k < 5; k++) begin
      checkHead(5, 18'h55, 12'(k), 2'd0, "R6 order");
      popSlice(5);
    end
    chk(sliceValid[5] === 1'b0, "R6 slice 5 drained", 64'(sliceValid[5]), 0);

    finishRun();
  end
endmodule